// File: doc/BRIEF.md
# Multiplexed Joypad Register

This block is the button register of a small handheld console. Eight buttons are wired into two groups of four. Software writes two active-low group-select bits, and each read returns one group as a nibble in which a pressed button reads as 0. Both groups can also be merged with an OR. With neither group selected, the nibble carries the index of the active controller instead of button state.

The nibble is rebuilt every clock from the live key inputs. Whenever any nibble bit falls from 1 to 0, the block raises a one-cycle keypad interrupt pulse, with no CPU access needed. A write also raises the pulse if it newly exposes a pressed button, because the stored nibble is treated as all ones at that instant. A static configuration pin can enable a filter for the direction group. The filter stops software from seeing both members of an opposing pair pressed together.

Top module: `jp_pad_top`

## Requirements
- R1: A write stores only bits 5:4 of `wr_data` as the select field; the other bits are discarded. Reset sets the select field to 2'b11 and `rd_data` to 8'hFF.
- R2: With select 2'b10, the nibble is taken from key bits 7:4.
- R3: With select 2'b01, the nibble is taken from key bits 3:0.
- R4: With select 2'b00, the nibble is the bitwise OR of key bits 7:4 and key bits 3:0.
- R5: With select 2'b11, the nibble is the controller index, zero-extended to four bits.
- R6: When the controller index is non-zero, every key input is treated as released.
- R7: Read data is formatted as {2'b11, select, ~nibble}: bits 7:6 are always 1, and a pressed key reads as 0.
- R8: `rd_data` is loaded on the clock edge that samples `rd_en`, and it holds its value at all other times. The value reflects the select field and the keys as of the previous cycle.
- R9: `kirq` is high for exactly one cycle, one clock after any bit of the active-low nibble falls from 1 to 0. This happens when a key is pressed, with no CPU access.
- R10: On a write, the previous nibble is taken as 4'hF. A key that is already pressed in the newly selected group therefore raises `kirq`. A write that exposes no pressed key does not.
- R11: Changes to keys outside the selected group, and key releases, never raise `kirq`.
- R12: With `filt_en` high and select 2'b10, read data bits 1:0 are forced to 1 when both read as 0. Bits 3:2 are handled the same way. No other select is affected, and neither is `kirq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_pressed | input | 8 | Live key vector, 1 = pressed |
| ctrl_idx | input | 2 | Current controller index |
| filt_en | input | 1 | Static enable for the opposing-direction filter |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Registered read data |
| kirq | output | 1 | One-cycle keypad interrupt pulse |

## Verification
A corrupted select field shows up in bits 5:4 on the very next read. It also shows as the wrong group in the low nibble. A stale or mis-updated nibble register shows up as extra, missing or doubled `kirq` pulses, exactly one clock after the offending key change. The scoreboard compares every read against a model built from the requirements, and a separate pulse counter confirms how many interrupt pulses follow each stimulus. The filter is exercised with both opposing pairs pressed, with the filter on and off, and with the filter enabled but the wrong group selected.

// File: rtl/jp_pkg.sv
package jp_pkg;
  // Active-low group select encoding
  typedef enum logic [1:0] {
    SEL_BOTH = 2'b00,
    SEL_LOW  = 2'b01,
    SEL_HIGH = 2'b10,
    SEL_ID   = 2'b11
  } jp_sel_e;

  localparam logic [1:0] SEL_RESET = 2'b11;
endpackage

// File: rtl/jp_sel_reg.sv
module jp_sel_reg #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output jp_pkg::jp_sel_e   sel_q,
  output jp_pkg::jp_sel_e   sel_d
);
  localparam int SEL_LSB = NIB_W;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[DATA_W-1:SEL_LSB+2], wr_data[SEL_LSB-1:0]};

  always_comb begin
    sel_d = sel_q;
    if (wr_en) begin
      sel_d = jp_pkg::jp_sel_e'(wr_data[SEL_LSB+1:SEL_LSB]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= jp_pkg::jp_sel_e'(jp_pkg::SEL_RESET);
    end else if (wr_en) begin
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/jp_key_mux.sv
module jp_key_mux #(
  parameter int NIB_W  = 4,
  parameter int CTRL_W = 2
) (
  input  logic [2*NIB_W-1:0] key_pressed,
  input  logic [CTRL_W-1:0]  ctrl_idx,
  input  jp_pkg::jp_sel_e    sel,
  output logic [NIB_W-1:0]   nib_n
);
  logic [2*NIB_W-1:0] keys_eff;
  logic [NIB_W-1:0]   nib_hi;
  logic [NIB_W-1:0]   nib_lo;
  logic [NIB_W-1:0]   nib_id;
  logic [NIB_W-1:0]   nib_act;

  // A non-zero controller index masks every button as released
  assign keys_eff = (ctrl_idx != '0) ? '0 : key_pressed;
  assign nib_hi   = keys_eff[2*NIB_W-1:NIB_W];
  assign nib_lo   = keys_eff[NIB_W-1:0];
  assign nib_id   = NIB_W'(ctrl_idx);

  always_comb begin
    unique case (sel)
      jp_pkg::SEL_HIGH: nib_act = nib_hi;
      jp_pkg::SEL_LOW:  nib_act = nib_lo;
      jp_pkg::SEL_BOTH: nib_act = nib_hi | nib_lo;
      default:          nib_act = nib_id;
    endcase
  end

  assign nib_n = ~nib_act;
endmodule

// File: rtl/jp_edge_irq.sv
module jp_edge_irq #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NIB_W-1:0] nib_n,
  output logic [NIB_W-1:0] nib_q,
  output logic             kirq
);
  logic [NIB_W-1:0] prev_n;
  logic [NIB_W-1:0] fall;
  logic             irq_d;

  // A write forces the stored nibble high before the new compare
  assign prev_n = wr_en ? '1 : nib_q;
  assign fall   = prev_n & ~nib_n;
  assign irq_d  = |fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q <= '1;
      kirq  <= 1'b0;
    end else begin
      nib_q <= nib_n;
      kirq  <= irq_d;
    end
  end
endmodule

// File: rtl/jp_read_port.sv
module jp_read_port #(
  parameter int NIB_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              filt_en,
  input  jp_pkg::jp_sel_e   sel_q,
  input  logic [NIB_W-1:0]  nib_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAIRS  = NIB_W / 2;
  localparam int FILL_W = DATA_W - NIB_W - 2;

  logic              filt_on;
  logic [NIB_W-1:0]  nib_f;
  logic [DATA_W-1:0] rd_d;

  assign filt_on = filt_en && (sel_q == jp_pkg::SEL_HIGH);

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    always_comb begin
      nib_f[2*p+1:2*p] = nib_q[2*p+1:2*p];
      if (filt_on && (nib_q[2*p+1:2*p] == 2'b00)) begin
        nib_f[2*p+1:2*p] = 2'b11;
      end
    end
  end

  if ((NIB_W % 2) != 0) begin : g_odd
    assign nib_f[NIB_W-1] = nib_q[NIB_W-1];
  end

  always_comb begin
    rd_d = rd_data;
    if (rd_en) begin
      rd_d = {{FILL_W{1'b1}}, sel_q, nib_f};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '1;
    end else if (rd_en) begin
      rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/jp_pad_top.sv
module jp_pad_top #(
  parameter int KEYS_W = 8,
  parameter int CTRL_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEYS_W-1:0] key_pressed,
  input  logic [CTRL_W-1:0] ctrl_idx,
  input  logic              filt_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              kirq
);
  localparam int NIB_W = KEYS_W / 2;

  jp_pkg::jp_sel_e  sel_q;
  jp_pkg::jp_sel_e  sel_d;
  logic [NIB_W-1:0] nib_n;
  logic [NIB_W-1:0] nib_q;

  jp_sel_reg #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sel_q   (sel_q),
    .sel_d   (sel_d)
  );

  jp_key_mux #(.NIB_W(NIB_W), .CTRL_W(CTRL_W)) u_mux (
    .key_pressed (key_pressed),
    .ctrl_idx    (ctrl_idx),
    .sel         (sel_d),
    .nib_n       (nib_n)
  );

  jp_edge_irq #(.NIB_W(NIB_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .nib_n (nib_n),
    .nib_q (nib_q),
    .kirq  (kirq)
  );

  jp_read_port #(.NIB_W(NIB_W), .DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .filt_en (filt_en),
    .sel_q   (sel_q),
    .nib_q   (nib_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/jp_pad_chk.sv
module jp_pad_chk #(
  parameter int KEYS_W = 8,
  parameter int CTRL_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [KEYS_W-1:0] key_pressed,
  input logic [CTRL_W-1:0] ctrl_idx,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              kirq,
  input logic [1:0]        sel_q
);
  localparam int SL = KEYS_W / 2;

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sel_q == $past(wr_data[SL+1:SL])); // R1
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sel_q)); // R1
  AST_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:DATA_W-2] == 2'b11); // R7
  AST_RD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data[SL+1:SL] == $past(sel_q)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R8
  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !wr_en && !$past(wr_en) && $stable(key_pressed) && $stable(ctrl_idx))
      |=> !kirq); // R11
endmodule

bind jp_pad_top jp_pad_chk #(.KEYS_W(KEYS_W), .CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .key_pressed (key_pressed),
  .ctrl_idx    (ctrl_idx),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .kirq        (kirq),
  .sel_q       (sel_q)
);

// File: tb/sim_jp_pad_top.sv
`timescale 1ns/1ps
module sim_jp_pad_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] key_pressed;
  logic [1:0] ctrl_idx;
  logic       filt_en;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       kirq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int irq_run = 0;
  int irq_maxrun = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  jp_pad_top u0 (
    .clk(clk), .rst_n(rst_n), .key_pressed(key_pressed), .ctrl_idx(ctrl_idx),
    .filt_en(filt_en), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .kirq(kirq)
  );

  // Notes which edges sampled a read strobe
  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: compares each read result against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s rd_data actual=%02h expected=%02h", t, rd_data, e);
      end
    end
    if (kirq === 1'b1) begin
      irq_cnt++;
      irq_run++;
      if (irq_run > irq_maxrun) irq_maxrun = irq_run;
    end else begin
      irq_run = 0;
    end
  end

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: pushes the expected value, then issues the read
  task automatic do_read(input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    idle(1);
  endtask

  task automatic set_keys(input logic [7:0] k);
    @(negedge clk);
    key_pressed = k;
    idle(2);
  endtask

  initial begin
    int base;
    rst_n = 1'b0; key_pressed = 8'h00; ctrl_idx = 2'd0; filt_en = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
    idle(3);
    check("R1 reset rd_data", int'(rd_data), 8'hFF);
    check("R9 reset kirq", int'(kirq), 0);
    rst_n = 1'b1;
    idle(2);
    do_read(8'hFF, "R1 R5 reset select id 0");

    // R2 upper group
    do_write(8'h20);
    set_keys(8'h80);
    do_read(8'hE7, "R2 upper group");
    // R1 low write bits discarded; R3 lower group
    set_keys(8'h00);
    do_write(8'h1A);
    do_read(8'hDF, "R1 R3 low bits ignored");
    set_keys(8'h05);
    do_read(8'hDA, "R3 lower group");
    // R4 merged
    do_write(8'hC0);
    set_keys(8'h21);
    do_read(8'hCC, "R4 OR of groups");
    // R5 / R6
    do_write(8'h30);
    @(negedge clk); ctrl_idx = 2'd2; idle(2);
    do_read(8'hFD, "R5 controller id");
    do_write(8'h20);
    set_keys(8'hFF);
    do_read(8'hEF, "R6 keys masked by ctrl");
    @(negedge clk); ctrl_idx = 2'd0; idle(2);
    do_read(8'hE0, "R7 all pressed read zero");

    // R8: read value taken at strobe, held afterwards
    set_keys(8'h00);
    check("R8 hold without strobe", int'(rd_data), 8'hE0);
    do_read(8'hEF, "R8 reload on strobe");

    // R9: key press alone pulses kirq once
    do_write(8'h10);
    idle(2);
    base = irq_cnt; irq_maxrun = 0;
    set_keys(8'h01);
    idle(3);
    check("R9 pulse on press", irq_cnt - base, 1);
    check("R9 pulse width", irq_maxrun, 1);
    // R11: release and other-group press do not pulse
    base = irq_cnt;
    set_keys(8'h00);
    set_keys(8'h40);
    idle(3);
    check("R11 no pulse release/other group", irq_cnt - base, 0);
    // R10: write exposing pressed key pulses; no pressed key in group does not
    base = irq_cnt;
    do_write(8'h20);
    idle(3);
    check("R10 write exposes key", irq_cnt - base, 1);
    set_keys(8'h00);
    base = irq_cnt;
    do_write(8'h10);
    idle(3);
    check("R10 write no key no pulse", irq_cnt - base, 0);

    // R12 filter
    do_write(8'h20);
    set_keys(8'hF0);
    do_read(8'hE0, "R12 filter off");
    @(negedge clk); filt_en = 1'b1; idle(1);
    base = irq_cnt;
    do_read(8'hEF, "R12 both pairs forced");
    set_keys(8'h30);
    do_read(8'hEF, "R12 right/left pair forced");
    set_keys(8'h10);
    do_read(8'hEE, "R12 single key untouched");
    do_write(8'h10);
    set_keys(8'h0F);
    do_read(8'hD0, "R12 other select unfiltered");
    @(negedge clk); filt_en = 1'b0;
    idle(2);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R8 reads pending actual=%0d expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule